// File: doc/BRIEF.md
# Preloaded Command Sequence Generator

The block stands in for the decoded message stream when the optical link is down. While `link_lost_i` is high it runs a local turn counter in bunch-slot cycles, emits a one-cycle turn pulse at the start of every simulated turn, and replays a table of up to 32 preloaded commands inside that turn. Each command has a sub-address, a data byte and a bunch-slot offset. The sub-address and data byte appear on the same valid/sub/data outputs that the real decoder drives. While the link is present the block is silent.

A host write port fills the table one entry at a time and sets the turn period, the number of active entries and the playback mode. In repetitive mode the active entries replay on every simulated turn. In single-shot mode a start pulse arms the generator, and the next turn plays the sequence exactly once.

Top module: `cmd_replay_gen`

## Requirements
- R1: While `link_lost_i` is low, `turn_o` and `msg_valid_o` stay low and the turn counter stays at slot 0. Playback restarts from slot 0 on the first clock edge at which `link_lost_i` is high.
- R2: While `link_lost_i` is high, `turn_o` is high for one cycle every P cycles, where P is the programmed period. The first pulse appears one cycle after the first edge with `link_lost_i` high. A period written below 2 is stored as 2.
- R3: Entries are issued strictly in table order, at most one per cycle. Entry i leaves the counter when the slot count is at or above its offset and entry i-1 has already been issued. Its message appears d(i) cycles after the turn pulse, where d(0)=ofs(0) and d(i)=max(ofs(i), d(i-1)+1).
- R4: Only entries 0 to count-1 are issued. A count of 0 issues nothing. A count written above 32 is stored as 32.
- R5: With `cfg_repeat_i`=1 the active entries are replayed from entry 0 in every simulated turn.
- R6: With `cfg_repeat_i`=0, a `start_i` pulse arms the block. The next turn start plays the sequence once, and later turns stay silent until the block is armed again. In repetitive mode `start_i` is ignored.
- R7: `busy_o` goes high in the cycle after `start_i` in single-shot mode. It stays high until the cycle in which the last active message appears, and in that cycle it reads low.
- R8: After reset `turn_o`, `msg_valid_o` and `busy_o` are low, the period is 3564 cycles, the count is 0 and the mode is single-shot.
- R9: A table write with `tbl_we_i` stores the sub-address, data and offset at index `tbl_idx_i`. Later playback delivers those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-slot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_lost_i | input | 1 | High when the optical signal is absent; enables the generator |
| cfg_we_i | input | 1 | Writes period, count and mode |
| cfg_period_i | input | 12 | Simulated turn length in slots |
| cfg_count_i | input | 6 | Number of active entries |
| cfg_repeat_i | input | 1 | 1 = repetitive, 0 = single-shot |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 5 | Table entry index |
| tbl_sub_i | input | 8 | Entry sub-address |
| tbl_dat_i | input | 8 | Entry data byte |
| tbl_ofs_i | input | 12 | Entry slot offset within the turn |
| start_i | input | 1 | Arms single-shot playback |
| turn_o | output | 1 | Simulated turn pulse |
| msg_valid_o | output | 1 | Replayed message valid |
| msg_sub_o | output | 8 | Replayed sub-address |
| msg_dat_o | output | 8 | Replayed data byte |
| busy_o | output | 1 | Single-shot sequence pending or running |

## Verification
The turn pulse and each message are both registered once after the slot counter. A message therefore shows up exactly d(i) cycles after the pulse of its turn, and the bench measures that distance at the falling edge instead of counting from the input change. `busy_o` is due one cycle after `start_i`, and it falls in the same cycle as the last message, so the bench reads it beside each message. Turn spacing is compared with the programmed period, and every turn's message count is checked when the next pulse arrives.

// File: rtl/cmd_replay_pkg.sv
package cmd_replay_pkg;
  localparam int SUB_W      = 8;
  localparam int DAT_W      = 8;
  localparam int BX_W       = 12;
  localparam int DEF_PERIOD = 3564;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [DAT_W-1:0] dat;
    logic [BX_W-1:0]  ofs;
  } cmd_t;
endpackage

// File: rtl/cmd_table.sv
module cmd_table
  import cmd_replay_pkg::*;
#(
  parameter int N_CMD = 32,
  localparam int IDX_W = $clog2(N_CMD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  cmd_t             wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cmd_t             rd_data_o
);
  cmd_t mem_q [N_CMD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CMD; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_CMD; i++)
        if (we_i && wr_idx_i == IDX_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  p_wr_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/turn_timer.sv
module turn_timer
  import cmd_replay_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [BX_W-1:0] period_i,
  output logic [BX_W-1:0] slot_o,
  output logic            turn_start_o,
  output logic            turn_o
);
  logic [BX_W-1:0] slot_q;
  logic            turn_q;

  assign turn_start_o = run_i && (slot_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      turn_q <= 1'b0;
    end else begin
      turn_q <= turn_start_o;
      if (!run_i)                                slot_q <= '0;
      else if (slot_q >= period_i - BX_W'(1))    slot_q <= '0;
      else                                       slot_q <= slot_q + BX_W'(1);
    end
  end

  assign slot_o = slot_q;
  assign turn_o = turn_q;

  // period is never below 2, so pulses never touch
  p_turn_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_q |=> !turn_q);
endmodule

// File: rtl/seq_player.sv
module seq_player
  import cmd_replay_pkg::*;
#(
  parameter int N_CMD = 32,
  localparam int IDX_W = $clog2(N_CMD),
  localparam int CNT_W = $clog2(N_CMD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             turn_start_i,
  input  logic [BX_W-1:0]  slot_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             repeat_i,
  input  logic             start_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  cmd_t             rd_data_i,
  output logic             valid_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [DAT_W-1:0] dat_o,
  output logic             busy_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             playing_q, armed_q;
  logic             launch, run, hit, last;
  logic [IDX_W-1:0] idx;

  assign launch   = turn_start_i && (count_i != '0) && (repeat_i || armed_q);
  assign run      = launch || (playing_q && !turn_start_i);
  assign idx      = launch ? '0 : ptr_q;
  assign rd_idx_o = idx;
  assign hit      = run && (slot_i >= rd_data_i.ofs);
  assign last     = CNT_W'(idx) == count_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      playing_q <= 1'b0;
      armed_q   <= 1'b0;
      valid_o   <= 1'b0;
      sub_o     <= '0;
      dat_o     <= '0;
    end else begin
      // a turn start consumes the arm, even with count 0
      armed_q <= !repeat_i && ((armed_q && !turn_start_i) || start_i);
      if (!run_i) begin
        playing_q <= 1'b0;
        ptr_q     <= '0;
        valid_o   <= 1'b0;
      end else begin
        playing_q <= run && !(hit && last);
        ptr_q     <= !run ? '0 : (hit ? idx + IDX_W'(1) : idx);
        valid_o   <= hit;
        if (hit) begin
          sub_o <= rd_data_i.sub;
          dat_o <= rd_data_i.dat;
        end
      end
    end
  end

  assign busy_o = armed_q | playing_q;

  p_ptr_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    playing_q |-> CNT_W'(ptr_q) < count_i);
endmodule

// File: rtl/cmd_replay_gen.sv
module cmd_replay_gen
  import cmd_replay_pkg::*;
#(
  parameter int N_CMD      = 32,
  parameter int RST_PERIOD = DEF_PERIOD,
  localparam int IDX_W = $clog2(N_CMD),
  localparam int CNT_W = $clog2(N_CMD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_lost_i,
  input  logic             cfg_we_i,
  input  logic [BX_W-1:0]  cfg_period_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             cfg_repeat_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [SUB_W-1:0] tbl_sub_i,
  input  logic [DAT_W-1:0] tbl_dat_i,
  input  logic [BX_W-1:0]  tbl_ofs_i,
  input  logic             start_i,
  output logic             turn_o,
  output logic             msg_valid_o,
  output logic [SUB_W-1:0] msg_sub_o,
  output logic [DAT_W-1:0] msg_dat_o,
  output logic             busy_o
);
  logic [BX_W-1:0]  period_q;
  logic [CNT_W-1:0] count_q;
  logic             repeat_q;
  logic [BX_W-1:0]  slot;
  logic             turn_start;
  logic [IDX_W-1:0] rd_idx;
  cmd_t             rd_data, wr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= BX_W'(RST_PERIOD);
      count_q  <= '0;
      repeat_q <= 1'b0;
    end else if (cfg_we_i) begin
      period_q <= (cfg_period_i < BX_W'(2)) ? BX_W'(2) : cfg_period_i;
      count_q  <= (cfg_count_i > CNT_W'(N_CMD)) ? CNT_W'(N_CMD) : cfg_count_i;
      repeat_q <= cfg_repeat_i;
    end
  end

  assign wr_data = '{sub: tbl_sub_i, dat: tbl_dat_i, ofs: tbl_ofs_i};

  cmd_table #(.N_CMD(N_CMD)) u_table (
    .clk_i, .rst_ni,
    .we_i      (tbl_we_i),
    .wr_idx_i  (tbl_idx_i),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  turn_timer u_timer (
    .clk_i, .rst_ni,
    .run_i        (link_lost_i),
    .period_i     (period_q),
    .slot_o       (slot),
    .turn_start_o (turn_start),
    .turn_o       (turn_o)
  );

  seq_player #(.N_CMD(N_CMD)) u_player (
    .clk_i, .rst_ni,
    .run_i        (link_lost_i),
    .turn_start_i (turn_start),
    .slot_i       (slot),
    .count_i      (count_q),
    .repeat_i     (repeat_q),
    .start_i      (start_i),
    .rd_idx_o     (rd_idx),
    .rd_data_i    (rd_data),
    .valid_o      (msg_valid_o),
    .sub_o        (msg_sub_o),
    .dat_o        (msg_dat_o),
    .busy_o       (busy_o)
  );

  p_silent_link_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_lost_i |=> !turn_o && !msg_valid_o);
endmodule

// File: tb/cmd_replay_gen_tb.sv
module cmd_replay_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        link_lost_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [11:0] cfg_period_i = '0;
  logic [5:0]  cfg_count_i = '0;
  logic        cfg_repeat_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [4:0]  tbl_idx_i = '0;
  logic [7:0]  tbl_sub_i = '0;
  logic [7:0]  tbl_dat_i = '0;
  logic [11:0] tbl_ofs_i = '0;
  logic        start_i = 1'b0;
  logic        turn_o, msg_valid_o, busy_o;
  logic [7:0]  msg_sub_o, msg_dat_o;

  always #4 clk = ~clk;

  cmd_replay_gen u_dut (.*, .clk_i(clk));

  // entry vectors: offset, sub, data, expected distance from turn pulse
  localparam int          NV = 5;
  localparam int          VOFS [NV] = '{0, 3, 3, 9, 12};
  localparam logic [7:0]  VSUB [NV] = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54};
  localparam logic [7:0]  VDAT [NV] = '{8'hA5, 8'h5A, 8'hC3, 8'h3C, 8'h99};
  localparam int          VDLY [NV] = '{0, 3, 4, 9, 12};

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  bit mon_en = 1'b0, chk_busy = 1'b0;
  int period_exp = 16, exp_first = 0, exp_rest = 0, n_act = 0;
  int rel = 0, k = 0, turns = 0, msgs = 0;

  always @(negedge clk) if (mon_en) begin
    if (turn_o) begin
      if (turns >= 1) begin
        chk(rel + 1 == period_exp, "R2 turn spacing", rel + 1, period_exp);
        if ((turns == 1 ? exp_first : exp_rest) >= 0)
          chk(k == (turns == 1 ? exp_first : exp_rest), "R4 messages per turn", k,
              turns == 1 ? exp_first : exp_rest);
      end
      rel = 0; k = 0; turns++;
    end else rel++;
    if (msg_valid_o) begin
      if (k < NV) begin
        chk(rel == VDLY[k], "R3 message distance", rel, VDLY[k]);
        chk(msg_sub_o == VSUB[k] && msg_dat_o == VDAT[k], "R9 message content",
            {msg_sub_o, msg_dat_o}, {VSUB[k], VDAT[k]});
        if (chk_busy) chk(busy_o == (k != n_act - 1), "R7 busy beside message", busy_o, k != n_act - 1);
      end else chk(1'b0, "R4 extra message", k, NV - 1);
      k++; msgs++;
    end
  end

  task automatic mon_start(input int per, input int first, input int rest, input bit cb, input int na);
    period_exp = per; exp_first = first; exp_rest = rest; chk_busy = cb; n_act = na;
    rel = 0; k = 0; turns = 0; msgs = 0; mon_en = 1'b1;
  endtask

  task automatic cfg(input int per, input int cnt, input bit rep);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_period_i = 12'(per); cfg_count_i = 6'(cnt); cfg_repeat_i = rep;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic silent_window(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (turn_o || msg_valid_o) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(turn_o == 1'b0, "R8 reset turn", turn_o, 0);
    chk(msg_valid_o == 1'b0, "R8 reset valid", msg_valid_o, 0);
    chk(busy_o == 1'b0, "R8 reset busy", busy_o, 0);
    rst_ni = 1'b1;

    // R8/R2: default period 3564, count 0 -> turns without messages
    @(negedge clk); link_lost_i = 1'b1;
    mon_start(3564, 0, 0, 1'b0, 0);
    repeat (3564 * 2 + 10) @(negedge clk);
    mon_en = 1'b0;
    chk(turns >= 2, "R8 default period turns", turns, 2);
    chk(msgs == 0, "R4 count zero after reset", msgs, 0);
    link_lost_i = 1'b0;

    // R9: load table from vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tbl_we_i = 1'b1; tbl_idx_i = 5'(i);
      tbl_sub_i = VSUB[i]; tbl_dat_i = VDAT[i]; tbl_ofs_i = 12'(VOFS[i]);
    end
    @(negedge clk); tbl_we_i = 1'b0;
    cfg(16, 4, 1'b1);

    // R1: link present -> silent
    silent_window(30, "R1 silent with link present");

    // R5: repetitive playback of 4 entries
    link_lost_i = 1'b1;
    mon_start(16, 4, 4, 1'b0, 4);
    repeat (16 * 4) @(negedge clk);
    mon_en = 1'b0;
    chk(turns >= 4, "R5 turns seen", turns, 4);
    chk(msgs >= 12, "R5 replay every turn", msgs, 12);

    // R1: link returns mid-run
    link_lost_i = 1'b0;
    silent_window(20, "R1 silent after link return");

    // R4/R3: five active entries
    cfg(16, 5, 1'b1);
    link_lost_i = 1'b1;
    mon_start(16, 5, 5, 1'b0, 5);
    repeat (16 * 3) @(negedge clk);
    mon_en = 1'b0;
    chk(msgs >= 10, "R4 five entries per turn", msgs, 10);
    link_lost_i = 1'b0;

    // R4: count 0 in repetitive mode
    cfg(16, 0, 1'b1);
    link_lost_i = 1'b1;
    mon_start(16, 0, 0, 1'b0, 0);
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    chk(turns >= 2 && msgs == 0, "R4 count zero silent", msgs, 0);
    link_lost_i = 1'b0;

    // R6: start ignored in repetitive mode
    cfg(16, 4, 1'b1);
    pulse_start();
    chk(busy_o == 1'b0, "R6 start ignored when repeating", busy_o, 0);

    // R6/R7: single-shot
    cfg(16, 4, 1'b0);
    pulse_start();
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    link_lost_i = 1'b1;
    mon_start(16, 4, 0, 1'b1, 4);
    repeat (16 * 4) @(negedge clk);
    mon_en = 1'b0;
    chk(msgs == 4, "R6 single-shot plays once", msgs, 4);
    chk(busy_o == 1'b0, "R7 busy low after sequence", busy_o, 0);

    // R6: re-arm while the turn counter runs
    mon_start(16, -1, -1, 1'b0, 4);
    pulse_start();
    repeat (16 * 3) @(negedge clk);
    mon_en = 1'b0;
    chk(msgs == 4, "R6 re-armed single-shot", msgs, 4);
    chk(busy_o == 1'b0, "R7 busy low after re-arm run", busy_o, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule